// File: doc/BRIEF.md
# Microcontroller Interrupt Control Unit

This unit collects the interrupt sources of a small 8-bit microcontroller core and decides when the core must leave its program and jump to the interrupt entry point. There are three core sources: a rising edge on an external pin, a change on any bit of a small input port, and a timer overflow pulse. There is also a wider group of peripheral requests, whose flags and enables arrive as plain buses. One 8-bit control register holds the global enable, the peripheral-group enable, and the enable and flag bit of each core source. Software reads and writes this register through a simple write strobe and a read bus.

When the global enable is set and any enabled source has its flag set, the unit raises a registered vector request. The core accepts it with a one-cycle acknowledge. In that cycle the unit asks for the return address to be pushed and presents the fixed entry address. The global enable then clears by itself. A return-from-interrupt strobe sets the global enable again. Flags are never cleared by hardware, so a flag that is still set causes a new vector as soon as the global enable comes back.

A software write that clears the global enable creates a hazard, because a vector request sampled in that same cycle would otherwise fire. For the one cycle after such a write, the unit forces a no-operation slot and suppresses the vector request. The request that was suppressed stays pending in its flag.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After synchronous reset, the control register reads 0x00, and vec_req, push_ret, nop_inject and vec_addr are all 0.
- R2: Control register layout: bit 7 is the global enable, bit 6 is the peripheral-group enable, bits 5/4/3 are the enables and bits 2/1/0 are the flags of the external-pin, port-change and timer sources, in that order. A write takes effect at the next clock edge, and reg_rd_data then shows the written value.
- R3: A source flag is set one clock after its event, whatever the state of its enable bit or the global enable. The events are a rising edge of ext_pin, a change of any bit of port_pins, and a high tmr_ovf.
- R4: When a hardware event and a software write to the same flag fall in the same cycle, the flag ends up set.
- R5: vec_req rises two clocks after the cycle in which the global enable and a core flag/enable pair are both set, counting from the writing edge. A source whose enable bit is clear never raises vec_req.
- R6: A peripheral request (periph_flag[i] and periph_en[i] both high) raises vec_req only while the peripheral-group enable is set.
- R7: While the global enable is clear, vec_req is low in the following cycle.
- R8: In a cycle where vec_ack and vec_req are both high, push_ret is 1 and vec_addr equals 0x0004. After that cycle the global enable reads 0 and vec_req is low.
- R9: Acceptance leaves the flags unchanged. A reti strobe sets the global enable, so a flag/enable pair that is still set raises vec_req again.
- R10: In the cycle after a write that clears the global enable, nop_inject is 1 and vec_req is 0. The suppressed source keeps its flag and vectors once the global enable is written to 1 again.
- R11: Without vec_req, vec_ack has no effect: push_ret stays 0, vec_addr stays 0 and the global enable keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write value |
| reg_rd_data | output | 8 | Control register contents |
| ext_pin | input | 1 | External interrupt pin (rising edge) |
| port_pins | input | PORT_W | Port watched for change |
| tmr_ovf | input | 1 | Timer overflow pulse |
| periph_flag | input | NPER | Peripheral request flags |
| periph_en | input | NPER | Peripheral request enables |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_ack | input | 1 | Core accepts the vector request |
| vec_req | output | 1 | Vector request to the core |
| vec_addr | output | PC_W | Entry address, valid while accepting |
| push_ret | output | 1 | Push return address strobe |
| nop_inject | output | 1 | Forced no-operation slot after a global-enable clear |

## Verification
The hardest situation to reach is the clearing-write hazard. To reach it, a request must already be registered from a set global enable in exactly the cycle that software writes the enable to 0. The stimulus first pulses the timer with its enable set, so that the flag is set before the write edge. It then writes a value that clears only bit 7 and keeps the flag bit at 1. It then checks that the following cycle shows the no-operation slot with no vector, and that the request returns once the global enable is rewritten. Random cycles that mix events, writes, reti and acknowledges are compared against the cycle model on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int CTRL_W   = 8;
    localparam int NSRC     = 3;
    localparam int IDX_TMR  = 0;
    localparam int IDX_PORT = 1;
    localparam int IDX_EXT  = 2;

    // Control register image, bit 7 down to bit 0.
    typedef struct packed {
        logic            gie;
        logic            grp;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] fl;
    } ctrl_t;

    function automatic ctrl_t to_ctrl(input logic [CTRL_W-1:0] raw);
        return ctrl_t'(raw);
    endfunction

    function automatic logic core_pending(input ctrl_t c);
        return |(c.fl & c.en);
    endfunction

endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin;
    end

    assign rise = pin & ~prev_q;
endmodule

// File: rtl/irq_port_change.sv
module irq_port_change #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pins,
    output logic             changed
);
    logic [WIDTH-1:0] last_q;
    logic [WIDTH-1:0] diff;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) last_q[b] <= 1'b0;
            else     last_q[b] <= pins[b];
        end
        assign diff[b] = pins[b] ^ last_q[b];
    end

    assign changed = |diff;
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [NSRC-1:0]   src_evt,
    input  logic              accept,
    input  logic              reti,
    output ctrl_t             ctrl,
    output logic              gie_clr_wr
);
    ctrl_t ctrl_q;
    ctrl_t wr_img;

    assign wr_img     = to_ctrl(wr_data);
    assign gie_clr_wr = wr_en & ~wr_img.gie;

    // Global enable: acceptance beats return, return beats software.
    always_ff @(posedge clk) begin
        if (rst)         ctrl_q.gie <= 1'b0;
        else if (accept) ctrl_q.gie <= 1'b0;
        else if (reti)   ctrl_q.gie <= 1'b1;
        else if (wr_en)  ctrl_q.gie <= wr_img.gie;
    end

    always_ff @(posedge clk) begin
        if (rst)        ctrl_q.grp <= 1'b0;
        else if (wr_en) ctrl_q.grp <= wr_img.grp;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)        ctrl_q.en[s] <= 1'b0;
            else if (wr_en) ctrl_q.en[s] <= wr_img.en[s];
        end

        // Hardware set has priority over a same-cycle software write.
        always_ff @(posedge clk) begin
            if (rst)             ctrl_q.fl[s] <= 1'b0;
            else if (src_evt[s]) ctrl_q.fl[s] <= 1'b1;
            else if (wr_en)      ctrl_q.fl[s] <= wr_img.fl[s];
        end

        a_r4_hw_set_wins: assert property (@(posedge clk) disable iff (rst)
            src_evt[s] |=> ctrl_q.fl[s]);
    end

    assign ctrl = ctrl_q;

    a_r8_gie_clears_on_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ctrl_q.gie);

    a_r9_reti_sets_gie: assert property (@(posedge clk) disable iff (rst)
        (reti && !accept) |=> ctrl_q.gie);
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
    import irq_pkg::*;
#(
    parameter int              NPER     = 8,
    parameter int              PC_W     = 13,
    parameter logic [PC_W-1:0] VEC_ADDR = 'h0004
) (
    input  logic            clk,
    input  logic            rst,
    input  ctrl_t           ctrl,
    input  logic [NPER-1:0] periph_flag,
    input  logic [NPER-1:0] periph_en,
    input  logic            gie_clr_wr,
    input  logic            vec_ack,
    output logic            vec_req,
    output logic            accept,
    output logic            nop_inject,
    output logic            push_ret,
    output logic [PC_W-1:0] vec_addr
);
    logic [NPER-1:0] per_hit;
    logic            per_any;
    logic            pending;
    logic            req_q;
    logic            nop_q;

    for (genvar p = 0; p < NPER; p++) begin : g_per
        assign per_hit[p] = periph_flag[p] & periph_en[p];
    end

    assign per_any = ctrl.grp & (|per_hit);
    assign pending = core_pending(ctrl) | per_any;

    // Sampled once per cycle. A cycle that is being accepted does not re-arm.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            nop_q <= 1'b0;
        end else begin
            req_q <= ctrl.gie & pending & ~accept;
            nop_q <= gie_clr_wr;
        end
    end

    assign vec_req    = req_q & ~nop_q;
    assign nop_inject = nop_q;
    assign accept     = vec_req & vec_ack;
    assign push_ret   = accept;
    assign vec_addr   = accept ? VEC_ADDR : '0;

    a_r6_group_gate: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.gie || (!core_pending(ctrl) && !ctrl.grp)) |=> !req_q);
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
    import irq_pkg::*;
#(
    parameter int NPER   = 8,
    parameter int PORT_W = 6,
    parameter int PC_W   = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [CTRL_W-1:0] reg_wr_data,
    output logic [CTRL_W-1:0] reg_rd_data,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              tmr_ovf,
    input  logic [NPER-1:0]   periph_flag,
    input  logic [NPER-1:0]   periph_en,
    input  logic              reti,
    input  logic              vec_ack,
    output logic              vec_req,
    output logic [PC_W-1:0]   vec_addr,
    output logic              push_ret,
    output logic              nop_inject
);
    localparam logic [PC_W-1:0] ENTRY = PC_W'(4);

    logic            ext_rise;
    logic            port_chg;
    logic [NSRC-1:0] src_evt;
    logic            accept;
    logic            gie_clr_wr;
    ctrl_t           ctrl;

    irq_pin_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_pin),
        .rise (ext_rise)
    );

    irq_port_change #(.WIDTH(PORT_W)) u_pchg (
        .clk     (clk),
        .rst     (rst),
        .pins    (port_pins),
        .changed (port_chg)
    );

    always_comb begin
        src_evt           = '0;
        src_evt[IDX_EXT]  = ext_rise;
        src_evt[IDX_PORT] = port_chg;
        src_evt[IDX_TMR]  = tmr_ovf;
    end

    irq_ctrl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .wr_data    (reg_wr_data),
        .src_evt    (src_evt),
        .accept     (accept),
        .reti       (reti),
        .ctrl       (ctrl),
        .gie_clr_wr (gie_clr_wr)
    );

    irq_vec_arb #(.NPER(NPER), .PC_W(PC_W), .VEC_ADDR(ENTRY)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .periph_flag (periph_flag),
        .periph_en   (periph_en),
        .gie_clr_wr  (gie_clr_wr),
        .vec_ack     (vec_ack),
        .vec_req     (vec_req),
        .accept      (accept),
        .nop_inject  (nop_inject),
        .push_ret    (push_ret),
        .vec_addr    (vec_addr)
    );

    assign reg_rd_data = ctrl;

    a_r7_no_vec_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_data[CTRL_W-1] |=> !vec_req);

    a_r10_nop_blocks_vector: assert property (@(posedge clk) disable iff (rst)
        nop_inject |-> !vec_req);

    a_r11_no_push_without_req: assert property (@(posedge clk) disable iff (rst)
        !vec_req |-> (!push_ret && vec_addr == '0));

    a_r10_nop_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && !reg_wr_data[CTRL_W-1]) |=> nop_inject);
endmodule

// File: tb/test_irq_ctrl_unit.sv
module test_irq_ctrl_unit;
    localparam int NPER = 8, PORT_W = 6, PC_W = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0; logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic ext_pin = 0; logic [PORT_W-1:0] port_pins = 0; logic tmr = 0;
    logic [NPER-1:0] pflag = 0, pen = 0;
    logic reti = 0, ack = 0;
    logic vreq, push, nop;
    logic [PC_W-1:0] vaddr;

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural model state
    bit m_gie, m_grp, m_req, m_nop, m_prev_pin;
    bit [2:0] m_en, m_fl; // index 2 ext, 1 port, 0 timer
    bit [PORT_W-1:0] m_prev_port;

    always #5 clk = ~clk;

    irq_ctrl_unit #(.NPER(NPER), .PORT_W(PORT_W), .PC_W(PC_W)) i_irq_ctrl_unit (
        .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_wr_data(wr_data),
        .reg_rd_data(rd_data), .ext_pin(ext_pin), .port_pins(port_pins),
        .tmr_ovf(tmr), .periph_flag(pflag), .periph_en(pen), .reti(reti),
        .vec_ack(ack), .vec_req(vreq), .vec_addr(vaddr), .push_ret(push),
        .nop_inject(nop)
    );

    task automatic model_reset();
        m_gie = 0; m_grp = 0; m_req = 0; m_nop = 0; m_prev_pin = 0;
        m_en = 0; m_fl = 0; m_prev_port = 0;
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare outputs for the current inputs, then advance one clock.
    task automatic step(input string tag);
        bit e_req, e_acc, pend;
        bit [2:0] ev;
        #1;
        e_req = m_req && !m_nop;
        e_acc = e_req && ack;
        cmp(tag, "reg", int'(rd_data), int'({m_gie, m_grp, m_en, m_fl}));
        cmp(tag, "vec_req", int'(vreq), int'(e_req));
        cmp(tag, "push", int'(push), int'(e_acc));
        cmp(tag, "addr", int'(vaddr), e_acc ? 4 : 0);
        cmp(tag, "nop", int'(nop), int'(m_nop));
        @(posedge clk);
        ev[2] = ext_pin && !m_prev_pin;
        ev[1] = (port_pins != m_prev_port);
        ev[0] = tmr;
        pend = ((m_fl & m_en) != 0) || (m_grp && ((pflag & pen) != 0));
        m_req = m_gie && pend && !e_acc;
        m_nop = wr_en && !wr_data[7];
        if (e_acc) m_gie = 0;
        else if (reti) m_gie = 1;
        else if (wr_en) m_gie = wr_data[7];
        if (wr_en) begin
            m_grp = wr_data[6]; m_en = wr_data[5:3]; m_fl = wr_data[2:0];
        end
        m_fl = m_fl | ev;
        m_prev_pin = ext_pin; m_prev_port = port_pins;
        @(negedge clk);
        wr_en = 0; tmr = 0; reti = 0; ack = 0;
    endtask

    task automatic wr(input logic [7:0] d, input string tag);
        wr_en = 1; wr_data = d; step(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        idle(1, "R1");
        // layout
        wr(8'h38, "R2"); idle(1, "R2");
        wr(8'h00, "R2"); idle(1, "R2");
        // events with everything masked
        tmr = 1; step("R3");
        ext_pin = 1; step("R3"); idle(1, "R3");
        port_pins = 6'h04; step("R3"); idle(2, "R3");
        // hw set beats software clear
        tmr = 1; wr(8'h00, "R4"); idle(1, "R4");
        // global with no source enabled: no vector
        wr(8'h80, "R5"); idle(3, "R5");
        // enable timer: vector appears
        wr(8'h8F, "R5"); idle(2, "R5");
        // accept
        ack = 1; step("R8"); idle(2, "R8");
        // flags still set, reti re-vectors
        reti = 1; step("R9"); idle(2, "R9");
        ack = 1; step("R9"); idle(1, "R9");
        // ack without request
        wr(8'h80, "R11"); idle(1, "R11");
        ack = 1; step("R11"); idle(1, "R11");
        // peripheral group gating
        pflag = 8'h10; pen = 8'h10; idle(3, "R6");
        wr(8'hC0, "R6"); idle(2, "R6");
        ack = 1; step("R6"); idle(1, "R6");
        pflag = 0; pen = 0;
        // global clear write: no vectoring
        wr(8'h08, "R7"); idle(3, "R7");
        // clearing-write hazard
        wr(8'h88, "R10"); idle(2, "R10");
        tmr = 1; step("R10");
        wr(8'h09, "R10"); idle(3, "R10");
        wr(8'h89, "R10"); idle(2, "R10");
        ack = 1; step("R10"); idle(1, "R10");
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            tmr = (r[2:0] == 0);
            ext_pin = r[3];
            if (r[7:4] == 0) port_pins = port_pins ^ 6'h21;
            pflag = {7'b0, r[8]}; pen = {7'b0, r[9]};
            reti = (r[13:10] == 0);
            ack = r[14] | r[15];
            if (r[19:16] == 0) begin wr_en = 1; wr_data = r[27:20]; end
            step("R5");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule